// File: doc/BRIEF.md
# 64-bit Global Timer with Self-Rearming Comparator

This block is a memory-mapped system timer. A 64-bit up-counter advances by one on each cycle in which the tick enable is high, once software has set the run bit. A single 64-bit comparator watches the counter. When the two are equal and the comparator is enabled, a sticky interrupt status bit is set. The interrupt output is high while both that status bit and its enable bit are high.

In one-shot use, software loads the comparator with a future count. In periodic use, the auto-increment bit is set, and each match adds a 32-bit step value to the comparator so that it re-arms itself.

Writes to the counter halves, comparator halves, step value and control register model a slower timer domain. Each one lands a fixed number of cycles after the bus write and then raises its own acknowledge bit. Software clears an acknowledge bit by writing 1 to it. Interrupt enable, interrupt status clears and acknowledge clears act on the next clock edge.

Top module: `gct_timer`

## Requirements
- R1: After reset, the counter, comparator, step value, control, all acknowledge bits and the interrupt status read as zero, and `irq` is low.
- R2: A write to the counter halves (0x100 low, 0x104 high), comparator halves (0x200 low, 0x204 high), step value (0x208) or control (0x240) becomes visible exactly APPLY_LAT cycles after the bus write. Until then, reads return the old value.
- R3: When a delayed write lands, it sets its acknowledge bit. Register 0x24C holds bit 0 for comparator low, bit 1 for comparator high, bit 2 for the step value and bit 16 for control. Register 0x110 holds bit 0 for counter low and bit 1 for counter high.
- R4: Writing 1 to an acknowledge bit clears it. Writing 0 leaves it unchanged.
- R5: A write to one counter half leaves the other half unchanged.
- R6: While control bit 8 is set, the counter advances by one on each cycle with `tick_en` high, carrying from the low half into the high half. In any other cycle it holds its value.
- R7: When control bit 0 is set and the counter equals the comparator, interrupt status bit 0 (0x244) is set on the next clock edge. Without auto-increment, the comparator is left unchanged.
- R8: When control bit 1 is also set, each match adds the step value to the comparator on that same edge, so a later match fires again.
- R9: `irq` equals status bit 0 AND enable bit 0 (0x248). The enable takes effect on the next edge.
- R10: Writing 1 to status bit 0 clears it. If a match occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance qualifier |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The cycle that needs the most care is one in which a comparator match and a software clear of the interrupt status fall on the same edge. The bench provokes this by parking the counter on the comparator value: it stops the ticks with comparator enabled and auto-increment off, so a match is present on every cycle. It then writes the clear. The bench expects the status and `irq` to remain set. After one more tick moves the counter past the comparator, a second clear must take the status to zero.

// File: rtl/gct_pkg.sv
package gct_pkg;
    localparam int HALF_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] A_CNT_WS = 12'h110;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h200;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h204;
    localparam logic [ADDR_W-1:0] A_STEP   = 12'h208;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] A_IRQ_ST = 12'h244;
    localparam logic [ADDR_W-1:0] A_IRQ_EN = 12'h248;
    localparam logic [ADDR_W-1:0] A_WS     = 12'h24C;

    localparam int CTRL_CEN_BIT  = 0;
    localparam int CTRL_AUTO_BIT = 1;
    localparam int CTRL_RUN_BIT  = 8;
    localparam int WS_CTRL_BIT   = 16;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_CNT_LO, TGT_CNT_HI, TGT_CMP_LO, TGT_CMP_HI, TGT_STEP, TGT_CTRL
    } tgt_e;

    typedef struct packed {
        logic              vld;
        tgt_e              tgt;
        logic [HALF_W-1:0] data;
    } stage_t;

    function automatic tgt_e addr_to_tgt(input logic [ADDR_W-1:0] a);
        case (a)
            A_CNT_LO: return TGT_CNT_LO;
            A_CNT_HI: return TGT_CNT_HI;
            A_CMP_LO: return TGT_CMP_LO;
            A_CMP_HI: return TGT_CMP_HI;
            A_STEP:   return TGT_STEP;
            A_CTRL:   return TGT_CTRL;
            default:  return TGT_NONE;
        endcase
    endfunction
endpackage

// File: rtl/gct_wr_pipe.sv
module gct_wr_pipe
    import gct_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t in_item,
    output stage_t out_item
);
    stage_t stg [LAT];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= in_item;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign out_item = stg[LAT-1];
endmodule

// File: rtl/gct_counter.sv
module gct_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                tick,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [HALF_W-1:0]   ld_val,
    output logic [2*HALF_W-1:0] value
);
    localparam int FW = 2 * HALF_W;

    always_ff @(posedge clk) begin
        if (rst)              value <= '0;
        else if (ld_lo)       value[HALF_W-1:0] <= ld_val;
        else if (ld_hi)       value[FW-1:HALF_W] <= ld_val;
        else if (run && tick) value <= value + FW'(1);
    end
endmodule

// File: rtl/gct_comparator.sv
module gct_comparator #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                auto_inc,
    input  logic [2*HALF_W-1:0] cnt,
    input  logic [HALF_W-1:0]   step,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [HALF_W-1:0]   ld_val,
    output logic [2*HALF_W-1:0] comp,
    output logic                hit
);
    localparam int FW = 2 * HALF_W;

    assign hit = en && (cnt == comp);

    always_ff @(posedge clk) begin
        if (rst)                  comp <= '0;
        else if (ld_lo)           comp[HALF_W-1:0] <= ld_val;
        else if (ld_hi)           comp[FW-1:HALF_W] <= ld_val;
        else if (hit && auto_inc) comp <= comp + FW'(step);
    end
endmodule

// File: rtl/gct_timer.sv
module gct_timer
    import gct_pkg::*;
#(
    parameter int APPLY_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int FW = 2 * HALF_W;

    tgt_e   wr_tgt;
    stage_t in_item, app;

    assign wr_tgt  = bus_wr ? addr_to_tgt(bus_addr) : TGT_NONE;
    assign in_item = '{vld: (wr_tgt != TGT_NONE), tgt: wr_tgt, data: bus_wdata};

    gct_wr_pipe #(.LAT(APPLY_LAT)) u_pipe (
        .clk(clk), .rst(rst), .in_item(in_item), .out_item(app)
    );

    logic ap_cnt_lo, ap_cnt_hi, ap_cmp_lo, ap_cmp_hi, ap_step, ap_ctrl;
    assign ap_cnt_lo = app.vld && (app.tgt == TGT_CNT_LO);
    assign ap_cnt_hi = app.vld && (app.tgt == TGT_CNT_HI);
    assign ap_cmp_lo = app.vld && (app.tgt == TGT_CMP_LO);
    assign ap_cmp_hi = app.vld && (app.tgt == TGT_CMP_HI);
    assign ap_step   = app.vld && (app.tgt == TGT_STEP);
    assign ap_ctrl   = app.vld && (app.tgt == TGT_CTRL);

    logic cnt_load, cmp_load;
    assign cnt_load = ap_cnt_lo || ap_cnt_hi;
    assign cmp_load = ap_cmp_lo || ap_cmp_hi;

    logic              run_q, cen_q, auto_q;
    logic [HALF_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cen_q  <= 1'b0;
            auto_q <= 1'b0;
            step_q <= '0;
        end else begin
            if (ap_ctrl) begin
                run_q  <= app.data[CTRL_RUN_BIT];
                cen_q  <= app.data[CTRL_CEN_BIT];
                auto_q <= app.data[CTRL_AUTO_BIT];
            end
            if (ap_step) step_q <= app.data;
        end
    end

    logic [FW-1:0] cnt, comp;
    logic          hit;

    gct_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run_q), .tick(tick_en),
        .ld_lo(ap_cnt_lo), .ld_hi(ap_cnt_hi), .ld_val(app.data), .value(cnt)
    );

    gct_comparator #(.HALF_W(HALF_W)) u_cmp (
        .clk(clk), .rst(rst), .en(cen_q), .auto_inc(auto_q), .cnt(cnt),
        .step(step_q), .ld_lo(ap_cmp_lo), .ld_hi(ap_cmp_hi), .ld_val(app.data),
        .comp(comp), .hit(hit)
    );

    logic       wr_ws, wr_cws, wr_ist, wr_ien;
    assign wr_ws  = bus_wr && (bus_addr == A_WS);
    assign wr_cws = bus_wr && (bus_addr == A_CNT_WS);
    assign wr_ist = bus_wr && (bus_addr == A_IRQ_ST);
    assign wr_ien = bus_wr && (bus_addr == A_IRQ_EN);

    logic [3:0] gws_q, gws_set, gws_clr;
    logic [1:0] cws_q, cws_set, cws_clr;
    logic       int_st_q, int_en_q;

    assign gws_set = {ap_ctrl, ap_step, ap_cmp_hi, ap_cmp_lo};
    assign gws_clr = wr_ws ? {bus_wdata[WS_CTRL_BIT], bus_wdata[2:0]} : 4'b0;
    assign cws_set = {ap_cnt_hi, ap_cnt_lo};
    assign cws_clr = wr_cws ? bus_wdata[1:0] : 2'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            gws_q    <= '0;
            cws_q    <= '0;
            int_st_q <= 1'b0;
            int_en_q <= 1'b0;
        end else begin
            gws_q <= (gws_q & ~gws_clr) | gws_set;
            cws_q <= (cws_q & ~cws_clr) | cws_set;
            if (hit)                          int_st_q <= 1'b1;
            else if (wr_ist && bus_wdata[0])  int_st_q <= 1'b0;
            if (wr_ien) int_en_q <= bus_wdata[0];
        end
    end

    assign irq = int_st_q & int_en_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[HALF_W-1:0];
            A_CNT_HI: bus_rdata = cnt[FW-1:HALF_W];
            A_CNT_WS: bus_rdata[1:0] = cws_q;
            A_CMP_LO: bus_rdata = comp[HALF_W-1:0];
            A_CMP_HI: bus_rdata = comp[FW-1:HALF_W];
            A_STEP:   bus_rdata = step_q;
            A_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = run_q;
                bus_rdata[CTRL_AUTO_BIT] = auto_q;
                bus_rdata[CTRL_CEN_BIT]  = cen_q;
            end
            A_IRQ_ST: bus_rdata[0] = int_st_q;
            A_IRQ_EN: bus_rdata[0] = int_en_q;
            A_WS: begin
                bus_rdata[WS_CTRL_BIT] = gws_q[3];
                bus_rdata[2:0]         = gws_q[2:0];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gct_timer_chk.sv
module gct_timer_chk #(
    parameter int HALF_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_en,
    input logic                irq,
    input logic [2*HALF_W-1:0] cnt,
    input logic [2*HALF_W-1:0] comp,
    input logic [HALF_W-1:0]   step,
    input logic                run,
    input logic                auto_inc,
    input logic                hit,
    input logic                int_stat,
    input logic                int_en,
    input logic                cnt_load,
    input logic                cmp_load
);
    localparam int FW = 2 * HALF_W;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0 && comp == '0 && !int_stat && !irq));

    p_count_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick_en) && !cnt_load) |=> cnt == $past(cnt));

    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (run && tick_en && !cnt_load) |=> cnt == $past(cnt) + FW'(1));

    p_match_sets_r7: assert property (@(posedge clk) disable iff (rst)
        hit |=> int_stat);

    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (hit && auto_inc && !cmp_load) |=> comp == $past(comp) + FW'($past(step)));

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> int_en);
endmodule

bind gct_timer gct_timer_chk #(.HALF_W(gct_pkg::HALF_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .irq(irq), .cnt(cnt), .comp(comp),
    .step(step_q), .run(run_q), .auto_inc(auto_q), .hit(hit),
    .int_stat(int_st_q), .int_en(int_en_q), .cnt_load(cnt_load), .cmp_load(cmp_load)
);

// File: tb/tb_gct_timer.sv
`timescale 1ns/1ps
module tb_gct_timer;
    import gct_pkg::*;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    gct_timer #(.APPLY_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic        is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t queue_q[$];
    event  sample_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    initial begin : monitor
        forever begin
            @(sample_ev);
            #1;
            while (queue_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = queue_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        queue_q.push_back(it);
        ->sample_ev;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        queue_q.push_back(it);
        ->sample_ev;
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_rd(A_CNT_LO, 32'h0, "R1 counter low");
        chk_rd(A_CNT_HI, 32'h0, "R1 counter high");
        chk_rd(A_CTRL,   32'h0, "R1 control");
        chk_rd(A_WS,     32'h0, "R1 ack status");
        chk_rd(A_IRQ_ST, 32'h0, "R1 irq status");
        chk_irq(1'b0, "R1 irq low");

        // R2 delayed apply, R3 ack
        bus_write(A_CNT_LO, 32'h10);
        chk_rd(A_CNT_LO, 32'h0, "R2 old value before apply");
        settle(LAT - 1);
        chk_rd(A_CNT_LO, 32'h10, "R2 value after apply");
        chk_rd(A_CNT_WS, 32'h1, "R3 counter-low ack");

        // R5 halves independent
        bus_write(A_CNT_HI, 32'h5);
        chk_rd(A_CNT_HI, 32'h0, "R2 high before apply");
        settle(LAT - 1);
        chk_rd(A_CNT_HI, 32'h5, "R2 high after apply");
        chk_rd(A_CNT_LO, 32'h10, "R5 low kept");
        chk_rd(A_CNT_WS, 32'h3, "R3 both counter acks");

        // R4 W1C of ack
        bus_write(A_CNT_WS, 32'h1);
        chk_rd(A_CNT_WS, 32'h2, "R4 clear bit0");
        bus_write(A_CNT_WS, 32'h0);
        chk_rd(A_CNT_WS, 32'h2, "R4 zero write no effect");
        bus_write(A_CNT_WS, 32'h2);
        chk_rd(A_CNT_WS, 32'h0, "R4 clear bit1");

        // R6 hold while stopped, carry while running
        bus_write(A_CNT_LO, 32'hFFFF_FFFE);
        bus_write(A_CNT_HI, 32'h0);
        settle(LAT);
        ticks(3);
        chk_rd(A_CNT_LO, 32'hFFFF_FFFE, "R6 hold when stopped");
        bus_write(A_CTRL, 32'h100);
        settle(LAT);
        chk_rd(A_WS, 32'h0001_0000, "R3 control ack bit16");
        ticks(4);
        chk_rd(A_CNT_LO, 32'h2, "R6 low after carry");
        chk_rd(A_CNT_HI, 32'h1, "R6 high after carry");
        bus_write(A_WS, 32'h0001_0000);
        chk_rd(A_WS, 32'h0, "R4 clear control ack");

        // R7 one-shot match
        bus_write(A_IRQ_EN, 32'h1);
        bus_write(A_CMP_LO, 32'h5);
        bus_write(A_CMP_HI, 32'h1);
        settle(LAT);
        chk_rd(A_WS, 32'h3, "R3 comparator acks");
        bus_write(A_CTRL, 32'h101);
        settle(LAT);
        chk_rd(A_IRQ_ST, 32'h0, "R7 no match yet");
        ticks(3);
        chk_rd(A_IRQ_ST, 32'h0, "R7 status one cycle after equality");
        chk_rd(A_IRQ_ST, 32'h1, "R7 status set");
        chk_irq(1'b1, "R9 irq high");
        chk_rd(A_CMP_LO, 32'h5, "R7 comparator unchanged");

        // R10 clear collides with match
        bus_write(A_IRQ_ST, 32'h1);
        chk_rd(A_IRQ_ST, 32'h1, "R10 set wins over clear");
        chk_irq(1'b1, "R10 irq stays");
        ticks(1);
        bus_write(A_IRQ_ST, 32'h1);
        chk_rd(A_IRQ_ST, 32'h0, "R10 clear");
        chk_irq(1'b0, "R10 irq low after clear");

        // R8 periodic
        bus_write(A_CTRL, 32'h100);
        bus_write(A_STEP, 32'h4);
        bus_write(A_CMP_LO, 32'h8);
        settle(LAT);
        bus_write(A_CTRL, 32'h103);
        settle(LAT);
        chk_rd(A_CTRL, 32'h103, "R2 control readback");
        ticks(2);
        chk_rd(A_CNT_LO, 32'h8, "R6 counter at match");
        chk_rd(A_CMP_LO, 32'hC, "R8 comparator advanced");
        chk_rd(A_IRQ_ST, 32'h1, "R8 status set");

        // R9 enable gating
        bus_write(A_IRQ_EN, 32'h0);
        chk_irq(1'b0, "R9 irq masked");
        chk_rd(A_IRQ_ST, 32'h1, "R9 status kept while masked");
        bus_write(A_IRQ_EN, 32'h1);
        chk_irq(1'b1, "R9 irq unmasked");
        bus_write(A_IRQ_ST, 32'h1);
        chk_rd(A_IRQ_ST, 32'h0, "R10 clear without match");
        ticks(4);
        chk_rd(A_CNT_LO, 32'hC, "R6 counter second match");
        chk_rd(A_CMP_LO, 32'h10, "R8 second advance");
        chk_rd(A_IRQ_ST, 32'h1, "R8 second status");
        chk_rd(A_CMP_HI, 32'h1, "R8 comparator high kept");

        settle(2);
        done = 1;
        summary();
        $finish;
    end
endmodule